// File: doc/BRIEF.md
# RAID6 Dual-Parity Accumulator

This block computes the two parity bytes of a dual-parity stripe, one byte position at a time. For each position the caller streams source bytes one per beat. Each beat carries the byte, its source index, an explicit GF(2^8) coefficient and a flag that marks the beat as coming from an all-zero block. The final beat of the position is marked. One cycle after that final beat the block presents the plain-XOR parity P and the weighted parity Q for that position, together with the position number.

An operation is opened with a start pulse. The pulse carries four settings:
- whether P is wanted,
- whether Q is wanted,
- whether coefficients follow the syndrome rule ({02} raised to the source index) or are taken from the beat,
- whether this pass continues an earlier one.

The block stores every position's result in a small local memory. A continued pass therefore resumes from the stored P and Q instead of zero. That lets a request with more sources than one pass allows be split into several passes. An engine without native resumption pays for this with three source slots per continued pass. The block reports the number of new-source slots usable in the current pass, and it drops any further sources of a position beyond that number.

Top module: `pq_parity_engine`

## Requirements
- R1: After reset `p_valid` and `q_valid` are low, `p_data` and `q_data` are zero, and `slot_limit` equals MAX_SRC.
- R2: P is the XOR of every accepted source byte of a position. It appears on `p_data` with `p_valid` high in the cycle after the beat with `in_last` is accepted, and `out_pos` carries that beat's `in_pos`.
- R3: Q is the XOR over accepted sources of coefficient times byte, multiplied in GF(2^8) reduced by the polynomial 0x11d. With `op_syn` = 0 the coefficient is `in_coef`.
- R4: With `op_syn` = 1 the coefficient is {02} raised to the power `in_idx` (0 to 254), and `in_coef` is ignored.
- R5: A beat with `in_zero` = 1 contributes to neither parity and uses no source slot. Its `in_last` still closes the position.
- R6: With `op_dis_p` = 1, `p_valid` stays low while Q is still produced. With `op_dis_q` = 1, `q_valid` stays low while P is still produced.
- R7: A start pulse that disables both P and Q is ignored, and the previous settings stay in force.
- R8: A start without `op_cont` begins every position from zero. A start with `op_cont` = 1 begins each position from the P and Q last produced for that position.
- R9: `slot_limit` is MAX_SRC after a plain start. After a continued start it is MAX_SRC-3 when NATIVE_CONT = 0. Non-zero sources of a position beyond `slot_limit` are ignored.
- R10: A coefficient of {00} adds nothing to Q, and {01} adds the source byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start pulse, latches the four settings below |
| op_cont | input | 1 | Continue from stored P/Q |
| op_dis_p | input | 1 | Suppress P output |
| op_dis_q | input | 1 | Suppress Q output |
| op_syn | input | 1 | Syndrome coefficients ({02}^index) |
| in_valid | input | 1 | Source beat present |
| in_pos | input | POS_W | Byte position of the beat |
| in_idx | input | 8 | Source index |
| in_coef | input | 8 | Explicit coefficient |
| in_data | input | 8 | Source byte |
| in_zero | input | 1 | Beat comes from an all-zero block |
| in_last | input | 1 | Final beat of the position |
| slot_limit | output | SLOT_W | New-source slots usable per position in this pass |
| p_valid | output | 1 | P result valid |
| p_data | output | 8 | P result |
| q_valid | output | 1 | Q result valid |
| q_data | output | 8 | Q result |
| out_pos | output | POS_W | Position of the result |

## Verification
The bench targets the GF(2^8) arithmetic at its edges. It uses coefficients {00} and {01}, high coefficients whose products need reduction, and syndrome powers up to index 200. A multiplier with the wrong polynomial or an off-by-one exponent would give a wrong Q. It runs a continued pass after a plain pass and a plain pass after that. A design that failed to reload or to clear its accumulator would leak or lose earlier sources. It also checks that zero-block beats are skipped without using a slot, that a doubly-disabled start leaves the settings alone, and that the slot cap counts exactly MAX_SRC or MAX_SRC-3 accepted sources. Counting the cap wrongly would show up as an extra or missing term in both parities.

// File: rtl/pq_pkg.sv
package pq_pkg;

  localparam logic [7:0] GF_RED = 8'h1d;  // low byte of x^8+x^4+x^3+x^2+1

  typedef struct packed {
    logic cont;
    logic dis_p;
    logic dis_q;
    logic syn;
  } pq_cfg_t;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_RED : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // {02}^e by square-and-multiply over the exponent bits
  function automatic logic [7:0] gf_pow2(input logic [7:0] e);
    logic [7:0] r;
    logic [7:0] base;
    r    = 8'h01;
    base = 8'h02;
    for (int k = 0; k < 8; k++) begin
      if (e[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

endpackage

// File: rtl/pq_coef_term.sv
module pq_coef_term
  import pq_pkg::*;
(
  input  logic       syn,
  input  logic [7:0] idx,
  input  logic [7:0] coef,
  input  logic [7:0] data,
  output logic [7:0] term
);

  logic [7:0] eff_coef;

  always_comb begin
    eff_coef = syn ? gf_pow2(idx) : coef;
    term     = gf_mul(eff_coef, data);
  end

  always_comb begin
    if (eff_coef == 8'h01) assert_unit_coef_R10: assert (term == data);
    if (eff_coef == 8'h00) assert_zero_coef_R10: assert (term == 8'h00);
  end

endmodule

// File: rtl/pq_frame.sv
module pq_frame #(
  parameter int MAX_SRC = 8,
  localparam int SLOT_W = $clog2(MAX_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_zero,
  input  logic [SLOT_W-1:0] slot_limit,
  output logic              first,
  output logic              take
);

  logic              mid;
  logic [SLOT_W-1:0] cnt;

  assign first = !mid;
  assign take  = in_valid && !in_zero && (cnt < slot_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mid <= 1'b0;
      cnt <= '0;
    end else if (in_valid) begin
      if (in_last) begin
        mid <= 1'b0;
        cnt <= '0;
      end else begin
        mid <= 1'b1;
        if (take) cnt <= cnt + 1'b1;
      end
    end
  end

  assert_slot_cap_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= SLOT_W'(MAX_SRC));

  assert_zero_noslot_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_zero && !in_last) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/pq_accum.sv
module pq_accum #(
  parameter int POS_DEPTH = 16,
  localparam int POS_W = $clog2(POS_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [POS_W-1:0] in_pos,
  input  logic [7:0]       in_data,
  input  logic [7:0]       term,
  input  logic             first,
  input  logic             take,
  input  logic             cont,
  input  logic             dis_p,
  input  logic             dis_q,
  output logic             p_valid,
  output logic [7:0]       p_data,
  output logic             q_valid,
  output logic [7:0]       q_data,
  output logic [POS_W-1:0] out_pos
);

  logic [7:0] mem_p [POS_DEPTH];
  logic [7:0] mem_q [POS_DEPTH];
  logic [7:0] acc_p, acc_q;
  logic [7:0] base_p, base_q, nxt_p, nxt_q;

  always_comb begin
    if (!first) begin
      base_p = acc_p;
      base_q = acc_q;
    end else if (cont) begin
      base_p = mem_p[in_pos];
      base_q = mem_q[in_pos];
    end else begin
      base_p = 8'h00;
      base_q = 8'h00;
    end
    nxt_p = base_p ^ (take ? in_data : 8'h00);
    nxt_q = base_q ^ (take ? term : 8'h00);
  end

  // result store, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (in_valid && in_last) begin
      mem_p[in_pos] <= nxt_p;
      mem_q[in_pos] <= nxt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_p   <= 8'h00;
      acc_q   <= 8'h00;
      p_valid <= 1'b0;
      q_valid <= 1'b0;
      p_data  <= 8'h00;
      q_data  <= 8'h00;
      out_pos <= '0;
    end else begin
      p_valid <= 1'b0;
      q_valid <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          p_valid <= !dis_p;
          q_valid <= !dis_q;
          p_data  <= dis_p ? 8'h00 : nxt_p;
          q_data  <= dis_q ? 8'h00 : nxt_q;
          out_pos <= in_pos;
        end else begin
          acc_p <= nxt_p;
          acc_q <= nxt_q;
        end
      end
    end
  end

  assert_p_latency_R2: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> $past(in_valid && in_last));

  assert_q_latency_R2: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> $past(in_valid && in_last));

  assert_p_off_R6: assert property (@(posedge clk) disable iff (rst)
    $past(dis_p) |-> !p_valid);

  assert_q_off_R6: assert property (@(posedge clk) disable iff (rst)
    $past(dis_q) |-> !q_valid);

endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine
  import pq_pkg::*;
#(
  parameter int MAX_SRC     = 8,
  parameter int NATIVE_CONT = 0,
  parameter int POS_DEPTH   = 16,
  localparam int POS_W  = $clog2(POS_DEPTH),
  localparam int SLOT_W = $clog2(MAX_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic              op_cont,
  input  logic              op_dis_p,
  input  logic              op_dis_q,
  input  logic              op_syn,
  input  logic              in_valid,
  input  logic [POS_W-1:0]  in_pos,
  input  logic [7:0]        in_idx,
  input  logic [7:0]        in_coef,
  input  logic [7:0]        in_data,
  input  logic              in_zero,
  input  logic              in_last,
  output logic [SLOT_W-1:0] slot_limit,
  output logic              p_valid,
  output logic [7:0]        p_data,
  output logic              q_valid,
  output logic [7:0]        q_data,
  output logic [POS_W-1:0]  out_pos
);

  localparam int RESERVED = (NATIVE_CONT != 0) ? 0 : 3;
  localparam logic [SLOT_W-1:0] FULL_SLOTS = SLOT_W'(MAX_SRC);
  localparam logic [SLOT_W-1:0] CONT_SLOTS = SLOT_W'(MAX_SRC - RESERVED);

  pq_cfg_t    cfg;
  logic       start_ok;
  logic       first, take;
  logic [7:0] term;

  assign start_ok = op_start && !(op_dis_p && op_dis_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      slot_limit <= FULL_SLOTS;
    end else if (start_ok) begin
      cfg        <= '{cont: op_cont, dis_p: op_dis_p, dis_q: op_dis_q, syn: op_syn};
      slot_limit <= op_cont ? CONT_SLOTS : FULL_SLOTS;
    end
  end

  pq_frame #(.MAX_SRC(MAX_SRC)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_zero    (in_zero),
    .slot_limit (slot_limit),
    .first      (first),
    .take       (take)
  );

  pq_coef_term u_term (
    .syn  (cfg.syn),
    .idx  (in_idx),
    .coef (in_coef),
    .data (in_data),
    .term (term)
  );

  pq_accum #(.POS_DEPTH(POS_DEPTH)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_pos   (in_pos),
    .in_data  (in_data),
    .term     (term),
    .first    (first),
    .take     (take),
    .cont     (cfg.cont),
    .dis_p    (cfg.dis_p),
    .dis_q    (cfg.dis_q),
    .p_valid  (p_valid),
    .p_data   (p_data),
    .q_valid  (q_valid),
    .q_data   (q_data),
    .out_pos  (out_pos)
  );

  assert_one_dest_R7: assert property (@(posedge clk) disable iff (rst)
    !(cfg.dis_p && cfg.dis_q));

  assert_both_off_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_dis_p && op_dis_q) |=> $stable(slot_limit));

endmodule

// File: tb/pq_parity_engine_bench.sv
`timescale 1ns/1ps
module pq_parity_engine_bench;

  localparam int MAX_SRC = 8;
  localparam int POS_W   = 4;
  localparam int SLOT_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_start = 0, op_cont = 0, op_dis_p = 0, op_dis_q = 0, op_syn = 0;
  logic in_valid = 0, in_zero = 0, in_last = 0;
  logic [POS_W-1:0] in_pos = '0;
  logic [7:0] in_idx = 0, in_coef = 0, in_data = 0;
  logic [SLOT_W-1:0] slot_limit;
  logic p_valid, q_valid;
  logic [7:0] p_data, q_data;
  logic [POS_W-1:0] out_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pq_parity_engine #(.MAX_SRC(MAX_SRC), .NATIVE_CONT(0), .POS_DEPTH(16)) u_pq_parity_engine (
    .clk(clk), .rst(rst), .op_start(op_start), .op_cont(op_cont),
    .op_dis_p(op_dis_p), .op_dis_q(op_dis_q), .op_syn(op_syn),
    .in_valid(in_valid), .in_pos(in_pos), .in_idx(in_idx), .in_coef(in_coef),
    .in_data(in_data), .in_zero(in_zero), .in_last(in_last),
    .slot_limit(slot_limit), .p_valid(p_valid), .p_data(p_data),
    .q_valid(q_valid), .q_data(q_data), .out_pos(out_pos)
  );

  // {d0,c0,d1,c1,d2,c2}
  localparam logic [47:0] VEC [6] = '{
    48'h11_01_22_02_33_04,
    48'h80_03_ff_ff_01_8e,
    48'h5a_00_a5_01_3c_00,
    48'hc3_1d_00_47_7e_fe,
    48'hff_80_ff_40_ff_20,
    48'h01_02_02_01_9b_53
  };

  // reference multiply: shift the multiplier right, reduce by 0x11d
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x;
    logic [7:0] bb, r;
    x = {1'b0, a}; bb = b; r = 0;
    while (bb != 0) begin
      if (bb[0]) r = r ^ x[7:0];
      x = x << 1;
      if (x[8]) x = x ^ 9'h11d;
      bb = bb >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_pow(input int e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = ref_mul(r, 8'h02);
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic c, input logic dp, input logic dq, input logic sy);
    op_start = 1; op_cont = c; op_dis_p = dp; op_dis_q = dq; op_syn = sy;
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic beat(input int pos, input int idx, input logic [7:0] coef,
                      input logic [7:0] data, input logic zero, input logic last);
    in_valid = 1; in_pos = POS_W'(pos); in_idx = 8'(idx); in_coef = coef;
    in_data = data; in_zero = zero; in_last = last;
    @(negedge clk);
    in_valid = 0; in_last = 0; in_zero = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ep, eq, sp, sq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 p_valid", p_valid, 0);
    chk("R1 q_valid", q_valid, 0);
    chk("R1 data", {p_data, q_data}, 0);
    chk("R1 slot_limit", slot_limit, MAX_SRC);

    // R2 R3 R10: table walk, explicit coefficients
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d0, c0, d1, c1, d2, c2;
      {d0, c0, d1, c1, d2, c2} = VEC[k];
      start(0, 0, 0, 0);
      beat(k, 0, c0, d0, 0, 0);
      beat(k, 1, c1, d1, 0, 0);
      beat(k, 2, c2, d2, 0, 1);
      chk("R2 p_valid", p_valid, 1);
      chk("R2 P", p_data, d0 ^ d1 ^ d2);
      chk("R3 R10 Q", q_data, ref_mul(c0, d0) ^ ref_mul(c1, d1) ^ ref_mul(c2, d2));
      chk("R2 out_pos", out_pos, k);
    end
    @(negedge clk);
    chk("R2 p_valid drops", p_valid, 0);

    // R4 syndrome coefficients
    start(0, 0, 0, 1);
    beat(6, 0,   8'hff, 8'h37, 0, 0);
    beat(6, 1,   8'hff, 8'hc9, 0, 0);
    beat(6, 5,   8'hff, 8'h80, 0, 0);
    beat(6, 200, 8'hff, 8'h5d, 0, 1);
    chk("R4 Q", q_data, ref_mul(ref_pow(0), 8'h37) ^ ref_mul(ref_pow(1), 8'hc9)
                       ^ ref_mul(ref_pow(5), 8'h80) ^ ref_mul(ref_pow(200), 8'h5d));
    chk("R4 P", p_data, 8'h37 ^ 8'hc9 ^ 8'h80 ^ 8'h5d);

    // R5 zero-block beat skipped
    start(0, 0, 0, 0);
    beat(7, 0, 8'h03, 8'h11, 0, 0);
    beat(7, 1, 8'h09, 8'h77, 1, 0);
    beat(7, 2, 8'h05, 8'h22, 0, 1);
    chk("R5 P", p_data, 8'h11 ^ 8'h22);
    chk("R5 Q", q_data, ref_mul(8'h03, 8'h11) ^ ref_mul(8'h05, 8'h22));

    // R6 P disabled
    start(0, 1, 0, 0);
    beat(8, 0, 8'h07, 8'h4e, 0, 0);
    beat(8, 1, 8'h02, 8'h91, 0, 1);
    chk("R6 p_valid off", p_valid, 0);
    chk("R6 q_valid", q_valid, 1);
    chk("R6 Q", q_data, ref_mul(8'h07, 8'h4e) ^ ref_mul(8'h02, 8'h91));

    // R7 both disabled: ignored, P stays disabled
    start(0, 1, 1, 0);
    beat(8, 0, 8'h01, 8'h12, 0, 1);
    chk("R7 p_valid", p_valid, 0);
    chk("R7 q_valid", q_valid, 1);
    chk("R7 Q", q_data, 8'h12);

    // R6 Q disabled
    start(0, 0, 1, 0);
    beat(8, 0, 8'h01, 8'h34, 0, 1);
    chk("R6 q_valid off", q_valid, 0);
    chk("R6 p_valid", p_valid, 1);
    chk("R6 P", p_data, 8'h34);

    // R8 R9 continuation
    start(0, 0, 0, 0);
    beat(9, 0, 8'h1b, 8'h6a, 0, 0);
    beat(9, 1, 8'hc0, 8'h0f, 0, 1);
    sp = 8'h6a ^ 8'h0f;
    sq = ref_mul(8'h1b, 8'h6a) ^ ref_mul(8'hc0, 8'h0f);
    start(1, 0, 0, 0);
    chk("R9 cont slot_limit", slot_limit, MAX_SRC - 3);
    beat(9, 2, 8'h33, 8'he1, 0, 0);
    beat(9, 3, 8'h99, 8'h58, 0, 1);
    chk("R8 cont P", p_data, sp ^ 8'he1 ^ 8'h58);
    chk("R8 cont Q", q_data, sq ^ ref_mul(8'h33, 8'he1) ^ ref_mul(8'h99, 8'h58));
    start(0, 0, 0, 0);
    chk("R9 plain slot_limit", slot_limit, MAX_SRC);
    beat(9, 0, 8'h05, 8'hab, 0, 1);
    chk("R8 fresh P", p_data, 8'hab);
    chk("R8 fresh Q", q_data, ref_mul(8'h05, 8'hab));

    // R9 cap on plain pass: 10 sources, first 8 count
    ep = 0; eq = 0;
    for (int i = 0; i < 10; i++) begin
      beat(2, i, 8'h01, 8'(i + 1), 0, i == 9);
      if (i < MAX_SRC) begin ep ^= 8'(i + 1); eq ^= 8'(i + 1); end
    end
    chk("R9 cap P", p_data, ep);
    chk("R9 cap Q", q_data, eq);

    // R9 cap on continued pass: 7 sources, first 5 count
    start(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) begin
      beat(2, i, 8'h02, 8'(8'h10 + i), 0, i == 6);
      if (i < MAX_SRC - 3) begin ep ^= 8'(8'h10 + i); eq ^= ref_mul(8'h02, 8'(8'h10 + i)); end
    end
    chk("R9 cont cap P", p_data, ep);
    chk("R9 cont cap Q", q_data, eq);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule